// File: doc/BRIEF.md
# 64b/66b Block Boundary Lock

This block sits right after the gearbox of a high-speed serial receive lane. It accepts 66-bit words whose block boundary sits at an unknown bit offset, and it finds that boundary by itself. Each transmitted block has 64 scrambled payload bits and a 2-bit sync header that is never scrambled. At the true boundary the two header bits always differ. The block tries candidate offsets one at a time. Any offset that shows a header of 00 or 11 while hunting is dropped, and the next one is tried.

No handshake with the transmitter is needed. The hunt starts by itself when reset is released. The block also recovers by itself when a burst of errors costs it the lock. Once locked, it outputs each realigned block as a 2-bit header and a 64-bit payload, together with the header's value bit. A later stage collects that bit to build the 32-bit sync header word.

An input bit-order reversal can be selected. It corrects lanes whose parallel interface delivers the last received bit in bit 0.

Top module: `shl_sync_lock`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `lock` is 0, `offset` is 0 and `out_valid` is 0.
- R2: A header is valid when its two bits differ (01 or 10). While unlocked, each accepted word with an invalid header advances `offset` by one, and 65 wraps to 0. Leaving lock also advances `offset` by one with the same wrap.
- R3: While unlocked, `lock` rises on the 64th consecutive valid header seen at one offset. An invalid header restarts that count.
- R4: `out_valid` is 1 in the cycle after an accepted word exactly when `lock` was 1 when that word arrived. Otherwise it is 0.
- R5: Input bit k is the k-th bit received. The window at offset o takes bits o..o+65 of the previous accepted word followed by the current one. Bits 0..1 of the window go to `out_hdr`, bits 2..65 go to `out_payload`, and window bit 0 goes to `out_sh_bit`.
- R6: While locked, blocks are counted in windows of 64 starting at lock. When the invalid headers inside one window reach 16, `lock` falls and the hunt resumes at the next offset.
- R7: While locked, fewer than 16 invalid headers in a window leave `lock` at 1 and `offset` unchanged.
- R8: With `bit_rev` at 1, in_data bit 65-k is taken as the k-th received bit before alignment.
- R9: A cycle with `in_valid` at 0 changes neither `lock` nor `offset` and gives `out_valid` 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_rev | input | 1 | Reverse input bit order |
| in_valid | input | 1 | A new gearbox word is present |
| in_data | input | 66 | Gearbox word |
| lock | output | 1 | Block boundary found (registered) |
| offset | output | 7 | Current candidate offset 0..65 (registered) |
| out_valid | output | 1 | Aligned block present on the outputs |
| out_hdr | output | 2 | Aligned sync header |
| out_sh_bit | output | 1 | Sync header value bit |
| out_payload | output | 64 | Aligned payload |

## Verification
Every result of an accepted word appears one clock after the edge that takes the word in. That covers `lock`, `offset`, `out_valid`, the header, the payload and the value bit. The bench drives inputs on the falling edge and compares all outputs on the next falling edge against a reference model. The model is built from the generated bit stream, so each comparison lands exactly one register stage after its stimulus. The explicit checks on locking, dropping lock and offset wrap are sampled on the same falling edges. They are made after the run has had enough accepted words for the hunt to finish.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned PAY_W = 64;
  localparam int unsigned HDR_W = 2;
  localparam int unsigned BLK_W = PAY_W + HDR_W;
  localparam int unsigned OFF_W = $clog2(BLK_W);

  // a header is usable only when its two bits disagree
  function automatic logic hdr_valid(input logic [HDR_W-1:0] h);
    return h[0] ^ h[1];
  endfunction

  // next candidate offset, wrapping after the last one
  function automatic logic [OFF_W-1:0] offset_next(input logic [OFF_W-1:0] o);
    return (o == OFF_W'(BLK_W - 1)) ? '0 : o + 1'b1;
  endfunction
endpackage

// File: rtl/shl_bitrev.sv
module shl_bitrev #(
  parameter int unsigned W = 66
) (
  input  logic         rev,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign dout[k] = rev ? din[W-1-k] : din[k];
  end
endmodule

// File: rtl/shl_window.sv
module shl_window
  import shl_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_word,
  input  logic [OFF_W-1:0] offset,
  output logic [W-1:0]     win
);
  localparam int unsigned CAT_W = 2 * W;

  logic [W-1:0]     prev_q;
  logic [CAT_W-1:0] cat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= '0;
    else if (in_valid) prev_q <= in_word;
  end

  // older word in the low half, so bit order equals arrival order
  assign cat = {in_word, prev_q};
  assign win = W'(cat >> offset);

  // R9: the history word only moves on accepted words
  a_r9_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prev_q));
endmodule

// File: rtl/shl_lock_fsm.sv
module shl_lock_fsm
  import shl_pkg::*;
#(
  parameter int unsigned LOCK_CNT  = 64,
  parameter int unsigned BAD_LIMIT = 16,
  parameter int unsigned BAD_WIN   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic             hdr_ok,
  output logic             lock_q,
  output logic [OFF_W-1:0] offset_q,
  output logic             ev_lock,
  output logic             ev_drop,
  output logic             ev_slip
);
  localparam int unsigned GW  = $clog2(LOCK_CNT);
  localparam int unsigned WW  = $clog2(BAD_WIN);
  localparam int unsigned BW  = $clog2(BAD_LIMIT);
  localparam int unsigned BW1 = BW + 1;

  logic [GW-1:0]  good_q;
  logic [WW-1:0]  blk_q;
  logic [BW-1:0]  bad_q;
  logic [BW1-1:0] bad_sum;
  logic           ev_wrap;

  always_comb begin
    bad_sum = {1'b0, bad_q} + BW1'(!hdr_ok);
    ev_slip = blk_valid && !lock_q && !hdr_ok;
    ev_lock = blk_valid && !lock_q && hdr_ok && (good_q == GW'(LOCK_CNT - 1));
    ev_drop = blk_valid && lock_q && (bad_sum == BW1'(BAD_LIMIT));
    ev_wrap = blk_valid && lock_q && !ev_drop && (blk_q == WW'(BAD_WIN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      offset_q <= '0;
      good_q   <= '0;
      blk_q    <= '0;
      bad_q    <= '0;
    end else if (blk_valid) begin
      if (!lock_q) begin
        if (ev_slip) begin
          offset_q <= offset_next(offset_q);
          good_q   <= '0;
        end else if (ev_lock) begin
          lock_q <= 1'b1;
          good_q <= '0;
          blk_q  <= '0;
          bad_q  <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        if (ev_drop) begin
          lock_q   <= 1'b0;
          offset_q <= offset_next(offset_q);
          good_q   <= '0;
          blk_q    <= '0;
          bad_q    <= '0;
        end else if (ev_wrap) begin
          blk_q <= '0;
          bad_q <= '0;
        end else begin
          blk_q <= blk_q + 1'b1;
          bad_q <= bad_sum[BW-1:0];
        end
      end
    end
  end

  // R2: hunting slip moves to the next offset with wrap
  a_r2_slip_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slip |=> (offset_q == (($past(offset_q) == OFF_W'(BLK_W - 1)) ? '0 : $past(offset_q) + 1'b1)));
  // R3: lock only rises after a full run of good headers
  a_r3_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(good_q) == GW'(LOCK_CNT - 1)) && $past(hdr_ok));
  // R6: lock only falls when the bad budget is used up
  a_r6_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(bad_q) == BW'(BAD_LIMIT - 1)) && !$past(hdr_ok));
  // R7: a locked lane keeps its offset unless it drops
  a_r7_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !ev_drop) |=> $stable(offset_q));
  // R9: idle cycles leave the search state alone
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> $stable(offset_q) && $stable(lock_q));
  a_r3_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_lock, ev_drop, ev_slip}));
endmodule

// File: rtl/shl_sync_lock.sv
module shl_sync_lock
  import shl_pkg::*;
#(
  parameter int unsigned LOCK_CNT  = 64,
  parameter int unsigned BAD_LIMIT = 16,
  parameter int unsigned BAD_WIN   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rev,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_data,
  output logic             lock,
  output logic [OFF_W-1:0] offset,
  output logic             out_valid,
  output logic [HDR_W-1:0] out_hdr,
  output logic             out_sh_bit,
  output logic [PAY_W-1:0] out_payload
);
  logic [BLK_W-1:0] word_ord;
  logic [BLK_W-1:0] win;
  logic             hdr_ok;
  logic             ev_lock;
  logic             ev_drop;
  logic             ev_slip;

  shl_bitrev #(.W(BLK_W)) u_rev (
    .rev  (bit_rev),
    .din  (in_data),
    .dout (word_ord)
  );

  shl_window #(.W(BLK_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (word_ord),
    .offset   (offset),
    .win      (win)
  );

  assign hdr_ok = hdr_valid(win[HDR_W-1:0]);

  shl_lock_fsm #(
    .LOCK_CNT  (LOCK_CNT),
    .BAD_LIMIT (BAD_LIMIT),
    .BAD_WIN   (BAD_WIN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_valid (in_valid),
    .hdr_ok    (hdr_ok),
    .lock_q    (lock),
    .offset_q  (offset),
    .ev_lock   (ev_lock),
    .ev_drop   (ev_drop),
    .ev_slip   (ev_slip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_hdr     <= '0;
      out_sh_bit  <= 1'b0;
      out_payload <= '0;
    end else begin
      out_valid <= in_valid && lock;
      if (in_valid) begin
        out_hdr     <= win[HDR_W-1:0];
        out_sh_bit  <= win[0];
        out_payload <= win[BLK_W-1:HDR_W];
      end
    end
  end

  // R4: aligned output only follows a word taken while locked
  a_r4_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(lock) && $past(in_valid));
  // R9: no output after an idle cycle
  a_r9_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R5: the value bit agrees with the header it came from
  a_r5_sh_bit_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sh_bit == out_hdr[0]));
endmodule

// File: tb/shl_sync_lock_test.sv
module shl_sync_lock_test;
  localparam int BW = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_rev = 1'b0;
  logic        in_valid = 1'b0;
  logic [65:0] in_data = '0;
  logic        lock;
  logic [6:0]  offset;
  logic        out_valid;
  logic [1:0]  out_hdr;
  logic        out_sh_bit;
  logic [63:0] out_payload;

  shl_sync_lock uut (
    .clk(clk), .rst_n(rst_n), .bit_rev(bit_rev), .in_valid(in_valid),
    .in_data(in_data), .lock(lock), .offset(offset), .out_valid(out_valid),
    .out_hdr(out_hdr), .out_sh_bit(out_sh_bit), .out_payload(out_payload)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int unsigned seed_hash;
  int phase = 0;
  longint wn = 0;
  bit bad_blk [0:4095];
  bit saw_drop;
  bit drop_off_ok;
  bit prev_lock;

  // reference state
  bit        m_lock;
  int        m_off, m_good, m_blk, m_bad;
  bit        e_valid, e_sh;
  logic [1:0]  e_hdr;
  logic [63:0] e_pay;

  function automatic bit hbit(longint b, int j);
    int unsigned x;
    x = (32'(b) * 32'h9E3779B1) ^ (32'(j) * 32'h85EBCA6B) ^ seed_hash;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x[3];
  endfunction

  // stream bit at arrival position p (block boundary where (p+phase)%66==0)
  function automatic bit sb(longint p);
    longint q, b;
    int j;
    if (p < 0) return 1'b0;
    q = p + phase;
    b = q / BW;
    j = int'(q % BW);
    if (j == 0) return hbit(b, 0);
    if (j == 1) return (b < 4096 && bad_blk[b]) ? hbit(b, 0) : ~hbit(b, 0);
    return hbit(b, j);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    string prq;
    prq = bit_rev ? "R8" : "R5";
    chk("R3", "lock", 64'(lock), 64'(m_lock));
    chk("R2", "offset", 64'(offset), 64'(m_off));
    chk("R4", "out_valid", 64'(out_valid), 64'(e_valid));
    if (e_valid) begin
      chk(prq, "out_hdr", 64'(out_hdr), 64'(e_hdr));
      chk(prq, "out_payload", out_payload, e_pay);
      chk("R5", "out_sh_bit", 64'(out_sh_bit), 64'(e_sh));
    end
    if (prev_lock && !lock && !saw_drop) begin
      saw_drop = 1'b1;
      drop_off_ok = (offset == 7'd0);
    end
    prev_lock = lock;
  endtask

  function automatic int nxt(int o);
    return (o == 65) ? 0 : o + 1;
  endfunction

  task automatic model_step();
    logic [65:0] w;
    bit ok;
    int nb;
    for (int j = 0; j < BW; j++) w[j] = sb(BW * (wn - 1) + m_off + j);
    e_valid = m_lock;
    e_hdr = w[1:0];
    e_pay = w[65:2];
    e_sh = w[0];
    ok = w[0] ^ w[1];
    if (!m_lock) begin
      if (!ok) begin
        m_off = nxt(m_off);
        m_good = 0;
      end else if (m_good == 63) begin
        m_lock = 1'b1; m_good = 0; m_blk = 0; m_bad = 0;
      end else m_good++;
    end else begin
      nb = m_bad + (ok ? 0 : 1);
      if (nb == 16) begin
        m_lock = 1'b0; m_off = nxt(m_off); m_good = 0; m_blk = 0; m_bad = 0;
      end else if (m_blk == 63) begin
        m_blk = 0; m_bad = 0;
      end else begin
        m_blk++; m_bad = nb;
      end
    end
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_outputs();
      if ($urandom_range(0, 3) != 0) begin
        in_valid = 1'b1;
        for (int k = 0; k < BW; k++) begin
          if (bit_rev) in_data[65-k] = sb(BW * wn + k);
          else         in_data[k]    = sb(BW * wn + k);
        end
        model_step();
        wn++;
      end else begin
        in_valid = 1'b0;
        in_data = 66'($urandom());
        e_valid = 1'b0;  // R9
      end
    end
  endtask

  task automatic restart(int ph, bit rv);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    bit_rev = rv;
    phase = ph;
    wn = 0;
    for (int i = 0; i < 4096; i++) bad_blk[i] = 1'b0;
    m_lock = 0; m_off = 0; m_good = 0; m_blk = 0; m_bad = 0;
    e_valid = 0; e_hdr = '0; e_pay = '0; e_sh = 0;
    saw_drop = 0; drop_off_ok = 0; prev_lock = 0;
    repeat (2) @(negedge clk);
    chk("R1", "lock in reset", 64'(lock), 64'd0);
    chk("R1", "offset in reset", 64'(offset), 64'd0);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic mark_bad(longint first, int cnt);
    for (int i = 0; i < cnt; i++) bad_blk[first + i] = 1'b1;
  endtask

  initial begin
    seed_hash = $urandom(32'd1977);
    seed_hash = $urandom();

    // in-order lane, boundary 49 bits in
    restart(17, 1'b0);
    run(700);
    chk("R3", "locked after hunt", 64'(lock), 64'd1);
    chk("R2", "found offset", 64'(offset), 64'd49);

    // a few errors within one window keep lock
    mark_bad(wn + 20, 10);
    run(200);
    chk("R7", "still locked after 10 errors", 64'(lock), 64'd1);
    chk("R7", "offset kept", 64'(offset), 64'd49);

    // an error burst drops lock, then the lane relocks by itself
    mark_bad(wn + 20, 40);
    run(900);
    chk("R6", "lock dropped on burst", 64'(saw_drop), 64'd1);
    chk("R6", "relocked after burst", 64'(lock), 64'd1);
    chk("R6", "relocked offset", 64'(offset), 64'd49);

    // reversed lane, boundary at the last offset, then wrap on drop
    restart(1, 1'b1);
    run(700);
    chk("R8", "locked with reversal", 64'(lock), 64'd1);
    chk("R8", "offset 65 with reversal", 64'(offset), 64'd65);
    mark_bad(wn + 20, 40);
    run(900);
    chk("R2", "drop seen at offset 65", 64'(saw_drop), 64'd1);
    chk("R2", "offset wrapped to 0", 64'(drop_off_ok), 64'd1);
    chk("R6", "relocked at 65", 64'(offset), 64'd65);

    // aligned lane at offset 0
    restart(0, 1'b0);
    run(500);
    chk("R3", "locked at offset 0", 64'(lock), 64'd1);
    chk("R2", "offset 0", 64'(offset), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule